// File: doc/BRIEF.md
# Modem Line Status Watcher

This block watches four modem handshake lines: clear-to-send, data-set-ready, ring indicator and carrier detect. Each line passes through a synchronizer. The block then offers an eight-bit status word that holds two things: the present level of every line, and a sticky flag for each line that records a change since the last read. Any raised flag, once enabled, produces a modem-status interrupt request for the downstream interrupt identifier. Reading the status word clears the flags.

A five-bit modem-control register sits alongside the watcher. Two of its bits drive the terminal-ready and request-to-send pins. One bit gates the interrupt output. Another bit turns on a loopback diagnostic mode. In that mode the watched lines are taken from the control bits and the pins are ignored, so the software can exercise the change logic without a cable attached.

A small sequencer has two states. After reset it sits in ST_FILL while the synchronizer fills, and no change is counted there. Once the fill count reaches its limit (FILL_DONE) it moves to ST_ARMED and stays there until the next reset. Because of this, line levels that are present at reset never show up as changes.

Top module: `modem_status_watch`

## Requirements
- R1: After reset the status word reads 0x00, the control readback is 0, terminal-ready, request-to-send, `msi_req` and `irq_out` are all low.
- R2: Status bits [7:4] show the synchronized levels: bit 7 carrier detect, bit 6 ring indicator, bit 5 data-set-ready, bit 4 clear-to-send. A pin change appears there after two clock edges.
- R3: Status bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier detect) set on either edge of their synchronized line. The flag is visible one edge after the new level is visible.
- R4: Status bit 2 sets only when the ring indicator goes from 1 to 0. A rising ring indicator sets no flag.
- R5: Each flag stays set until a status read (`stat_rd` high at a clock edge). That read clears all four flags.
- R6: When a change event lands on the same edge as a read, its flag is set after that edge. The other flags are cleared.
- R7: `msi_req` is high exactly when `ms_ie` is high and at least one flag is set. `irq_out` equals `msi_req` AND control bit 3.
- R8: A control write (`mctl_we`) stores `mctl_wdata`, which reads back on `mctl_rdata`. Bit 0 drives `dtr_out` and bit 1 drives `rts_out`, in both normal and loopback mode.
- R9: With control bit 4 set (loopback), the lines are sourced as follows, and pin activity has no effect:
  - clear-to-send from control bit 1
  - data-set-ready from bit 0
  - ring indicator from bit 2
  - carrier detect from bit 3
- R10: Line levels present when reset is released set no flag. Only changes after the synchronizer has filled are recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_cts | input | 1 | Clear-to-send line, active high |
| pin_dsr | input | 1 | Data-set-ready line, active high |
| pin_ri | input | 1 | Ring indicator line, active high |
| pin_dcd | input | 1 | Carrier detect line, active high |
| mctl_we | input | 1 | Modem-control write strobe |
| mctl_wdata | input | 5 | Modem-control write value |
| mctl_rdata | output | 5 | Modem-control readback |
| stat_rd | input | 1 | Status read strobe; clears flags at the clock edge |
| stat_rdata | output | 8 | Status word: levels [7:4], change flags [3:0] |
| ms_ie | input | 1 | Modem-status interrupt enable |
| msi_req | output | 1 | Modem-status interrupt request |
| irq_out | output | 1 | Interrupt output gated by control bit 3 |
| dtr_out | output | 1 | Terminal-ready pin drive |
| rts_out | output | 1 | Request-to-send pin drive |

## Verification
The embedded properties are checked on every cycle:
- flags stay set unless a read occurs
- a read with no coinciding event empties the flags
- a ring flag only rises after a one-to-zero step of the synchronized line
- no flag appears before the sequencer arms
- an interrupt request never rises without its enable

Some behaviour can only be shown by the bench scenarios:
- the exact latency of levels and flags
- the full sixteen-by-sixteen sweep of line transitions against arithmetic expectations
- the same-edge read race
- loopback routing of every control pattern
- pin isolation while in loopback

// File: rtl/msd_pkg.sv
package msd_pkg;
    localparam int NLINES  = 4;
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_DCD = 3;
    localparam int MCTL_W  = 5;
    localparam int MC_DTR  = 0;
    localparam int MC_RTS  = 1;
    localparam int MC_AUX  = 2;
    localparam int MC_GATE = 3;
    localparam int MC_LOOP = 4;
    // lines whose flag records only a falling edge
    localparam logic [NLINES-1:0] FALL_ONLY = 4'b0100;

    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_ARMED = 1'b1
    } seq_state_t;
endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] chain [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= '0;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/msd_seq.sv
module msd_seq
    import msd_pkg::*;
#(
    parameter int FILL_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic armed
);
    localparam int CW = $clog2(FILL_CYCLES + 1) + 1;

    seq_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          fill_done;

    assign fill_done = (cnt_q == CW'(FILL_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        armed   = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                if (fill_done) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                armed = 1'b1;
            end
            default: state_d = ST_FILL;
        endcase
    end

    AST_ARMED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed); // R10
endmodule

// File: rtl/msd_delta.sv
module msd_delta #(
    parameter int               W        = 4,
    parameter logic [W-1:0]     FALLMASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         armed,
    input  logic         rd_clr,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] evt,
    output logic [W-1:0] flags
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_line
            if (FALLMASK[i]) begin : g_fall
                assign evt[i] = armed & prev_q[i] & ~lvl[i];

                AST_RI_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                    $rose(flags[i]) |-> (!$past(lvl[i]) && $past(lvl[i], 2))); // R4
            end else begin : g_both
                assign evt[i] = armed & (prev_q[i] ^ lvl[i]);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      flags[i] <= 1'b0;
                else if (evt[i]) flags[i] <= 1'b1;
                else if (rd_clr) flags[i] <= 1'b0;
            end
        end
    endgenerate

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr |=> (($past(flags) & ~flags) == '0)); // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (evt == '0)) |=> (flags == '0)); // R5
endmodule

// File: rtl/msd_ctrl.sv
module msd_ctrl
    import msd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MCTL_W-1:0] wdata,
    input  logic [NLINES-1:0] pins,
    output logic [MCTL_W-1:0] mctl,
    output logic [NLINES-1:0] line_src
);
    logic [NLINES-1:0] loop_src;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  mctl <= '0;
        else if (we) mctl <= wdata;
    end

    always_comb begin
        loop_src          = '0;
        loop_src[IDX_CTS] = mctl[MC_RTS];
        loop_src[IDX_DSR] = mctl[MC_DTR];
        loop_src[IDX_RI]  = mctl[MC_AUX];
        loop_src[IDX_DCD] = mctl[MC_GATE];
    end

    assign line_src = mctl[MC_LOOP] ? loop_src : pins;

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mctl == $past(wdata))); // R8
endmodule

// File: rtl/modem_status_watch.sv
module modem_status_watch
    import msd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_cts,
    input  logic              pin_dsr,
    input  logic              pin_ri,
    input  logic              pin_dcd,
    input  logic              mctl_we,
    input  logic [MCTL_W-1:0] mctl_wdata,
    output logic [MCTL_W-1:0] mctl_rdata,
    input  logic              stat_rd,
    output logic [7:0]        stat_rdata,
    input  logic              ms_ie,
    output logic              msi_req,
    output logic              irq_out,
    output logic              dtr_out,
    output logic              rts_out
);
    localparam int FILL_CYCLES = SYNC_STAGES + 1;

    logic [NLINES-1:0] pins_v;
    logic [NLINES-1:0] line_src;
    logic [NLINES-1:0] lvl;
    logic [NLINES-1:0] evt;
    logic [NLINES-1:0] st_flags;
    logic [MCTL_W-1:0] mctl_q;
    logic              armed;

    always_comb begin
        pins_v          = '0;
        pins_v[IDX_CTS] = pin_cts;
        pins_v[IDX_DSR] = pin_dsr;
        pins_v[IDX_RI]  = pin_ri;
        pins_v[IDX_DCD] = pin_dcd;
    end

    msd_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (mctl_we),
        .wdata    (mctl_wdata),
        .pins     (pins_v),
        .mctl     (mctl_q),
        .line_src (line_src)
    );

    msd_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (line_src),
        .q_out (lvl)
    );

    msd_seq #(.FILL_CYCLES(FILL_CYCLES)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (armed)
    );

    msd_delta #(.W(NLINES), .FALLMASK(FALL_ONLY)) u_delta (
        .clk    (clk),
        .rst_n  (rst_n),
        .armed  (armed),
        .rd_clr (stat_rd),
        .lvl    (lvl),
        .evt    (evt),
        .flags  (st_flags)
    );

    assign stat_rdata = {lvl[IDX_DCD], lvl[IDX_RI], lvl[IDX_DSR], lvl[IDX_CTS],
                         st_flags[IDX_DCD], st_flags[IDX_RI],
                         st_flags[IDX_DSR], st_flags[IDX_CTS]};
    assign msi_req    = ms_ie & (|st_flags);
    assign irq_out    = msi_req & mctl_q[MC_GATE];
    assign mctl_rdata = mctl_q;
    assign dtr_out    = mctl_q[MC_DTR];
    assign rts_out    = mctl_q[MC_RTS];

    AST_NO_FLAG_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |=> (st_flags == '0)); // R10
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msi_req) |-> ms_ie); // R7
endmodule

// File: tb/modem_status_watch_test.sv
module modem_status_watch_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pins = 4'h0;   // [0] cts [1] dsr [2] ri [3] dcd
    logic       mctl_we = 1'b0;
    logic [4:0] mctl_wdata = '0;
    logic [4:0] mctl_rdata;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic       ms_ie = 1'b0;
    logic       msi_req, irq_out, dtr_out, rts_out;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_status_watch uut (
        .clk(clk), .rst_n(rst_n),
        .pin_cts(pins[0]), .pin_dsr(pins[1]), .pin_ri(pins[2]), .pin_dcd(pins[3]),
        .mctl_we(mctl_we), .mctl_wdata(mctl_wdata), .mctl_rdata(mctl_rdata),
        .stat_rd(stat_rd), .stat_rdata(stat_rdata),
        .ms_ie(ms_ie), .msi_req(msi_req), .irq_out(irq_out),
        .dtr_out(dtr_out), .rts_out(rts_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic do_write(input logic [4:0] v);
        @(negedge clk); mctl_we = 1'b1; mctl_wdata = v;
        @(negedge clk); mctl_we = 1'b0;
    endtask

    function automatic logic [3:0] exp_flags(input logic [3:0] a, input logic [3:0] b);
        return ((a ^ b) & 4'b1011) | (a & ~b & 4'b0100);
    endfunction

    // status upper nibble order: dcd, ri, dsr, cts
    function automatic logic [3:0] lvl_nib(input logic [3:0] l);
        return {l[3], l[2], l[1], l[0]};
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_bad++; n_chk++;
                $display("FAIL watchdog expired");
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin
        pins = 4'hF;
        wait_neg(2);
        chk("R1 status", stat_rdata, 8'h00);
        chk("R1 ctrl", {mctl_rdata, dtr_out, rts_out, msi_req, irq_out}, 9'h0);
        rst_n = 1'b1;
        ms_ie = 1'b1;
        wait_neg(6);
        chk("R10 no flag from reset levels", stat_rdata, 8'hF0);
        chk("R10 no irq", msi_req, 1'b0);

        // latency: level after two edges, flag one edge later
        do_read();
        pins = 4'hE;                         // cts falls, at negedge
        wait_neg(2);
        chk("R2 level latency", stat_rdata, 8'hE0);
        wait_neg(1);
        chk("R3 flag latency", stat_rdata, 8'hE1);

        // exhaustive transition sweep
        do_write(5'b01000);                  // gate on
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                pins = 4'(a);
                wait_neg(5);
                do_read();
                ms_ie = a[0] ^ b[1];
                pins = 4'(b);
                wait_neg(5);
                chk("R3 R4 R2 status", stat_rdata, {lvl_nib(4'(b)), exp_flags(4'(a), 4'(b))});
                chk("R7 msi", msi_req, ms_ie & (|exp_flags(4'(a), 4'(b))));
                chk("R7 irq", irq_out, ms_ie & (|exp_flags(4'(a), 4'(b))));
                wait_neg(3);
                chk("R5 sticky", stat_rdata[3:0], exp_flags(4'(a), 4'(b)));
                do_read();
                chk("R5 cleared", stat_rdata[3:0], 4'h0);
            end
        end

        // gate off: irq_out blocked
        ms_ie = 1'b1;
        do_write(5'b00000);
        pins = 4'h0; wait_neg(5); do_read();
        pins = 4'h1; wait_neg(5);
        chk("R7 msi with gate off", msi_req, 1'b1);
        chk("R7 irq gated", irq_out, 1'b0);

        // same-edge read race: cts flag set, dsr event lands on read edge
        do_read();
        pins = 4'h0; wait_neg(5);            // cts falls -> flag0
        chk("R6 setup", stat_rdata[3:0], 4'h1);
        pins = 4'h2;                         // dsr rises
        wait_neg(2);                         // level now synced, event pending
        stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        chk("R6 race keeps new flag", stat_rdata[3:0], 4'h2);

        // loopback routing sweep; pins held fixed
        pins = 4'h5;
        for (int v = 0; v < 16; v++) begin
            do_write({1'b1, 4'(v)});
            wait_neg(5);
            chk("R9 loop levels", stat_rdata[7:4], {v[3], v[2], v[0], v[1]});
            chk("R8 dtr rts", {dtr_out, rts_out}, {v[0], v[1]});
            chk("R8 readback", mctl_rdata, {1'b1, 4'(v)});
        end
        do_read();
        pins = 4'hA; wait_neg(6);
        chk("R9 pins ignored", stat_rdata, 8'hF0);

        // back to normal mode: dtr/rts follow register
        do_write(5'b00011);
        wait_neg(1);
        chk("R8 normal dtr rts", {dtr_out, rts_out}, 2'b11);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule